// File: doc/BRIEF.md
# DRAM Row Boundary Chip-Select Decoder

This block turns a host memory address into one active-low chip-select for each physical DRAM row. Software fills a small bank of 8-bit boundary registers through a plain offset/data/write-strobe port. Each register gives the cumulative top of memory in 8 MB units. On every cycle where the address is marked valid, the decoder compares the address against these boundaries. One clock later it drives the chip-select of the matching row, or it raises a no-row-hit flag.

The address is selected by the first row whose boundary lies above it, as long as the address is also below the top of populated memory (the last used boundary). This rule still gives exactly one outcome when software programs boundaries that do not rise from row to row. If a row's boundary equals or falls below the one before it, that row becomes empty.

Top module: `dram_row_decoder`

## Requirements
- R1: Eight read/write 8-bit boundary registers sit at offsets 60h through 67h. Each one resets to 01h, and a read of any of these offsets returns the value last stored there.
- R2: A write to an offset outside 60h–67h changes no register, and a read of such an offset returns 00h.
- R3: A register value V stands for a boundary at V × 8 MB. Register 60h+k holds the cumulative top of rows 0 through k.
- R4: Row 0 (row_cs_n bit 0 low) is selected for every address below register 60h × 8 MB, provided that address is also below the top of memory (register 63h × 8 MB).
- R5: Row n ≥ 1 is selected when the address is at or above every lower row's boundary and below its own boundary. A row whose boundary does not exceed every earlier boundary is never selected, and this holds for non-rising register values too.
- R6: An address at or above register 63h × 8 MB sets no_row_hit and leaves all chip-selects high.
- R7: Never more than one chip-select is low. After a valid address, exactly one of the following is active: a single chip-select or no_row_hit.
- R8: Outputs are registered, so they reflect the address presented with host_valid on the previous clock edge. After a cycle with host_valid low, all chip-selects are high and no_row_hit is low.
- R9: The registers at 64h–67h have no effect on decode.
- R10: During and just after reset, all chip-selects are high and no_row_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_offset | input | 8 | Register offset for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data for cfg_offset (combinational) |
| host_addr | input | 32 | Host memory address |
| host_valid | input | 1 | Address valid |
| row_cs_n | output | 4 | Active-low chip-select per row |
| no_row_hit | output | 1 | Valid address matched no row |

## Verification
The assertions check the following on every cycle:
- at most one chip-select is low;
- a valid address always produces exactly one outcome;
- outputs go idle after an invalid cycle;
- out-of-range reads return zero.

Only the bench scenarios can show that each row's edges land on the correct 8 MB multiples. The same goes for:
- non-rising and zero boundaries, which leave the correct rows empty;
- the upper four registers, which leave decode untouched;
- writes to stray offsets, which are discarded.

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 8,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 8,
  parameter int NUM_ROWS   = 4,
  parameter int UNIT_SHIFT = 23,
  parameter logic [7:0] REG_BASE  = 8'h60,
  parameter logic [7:0] RESET_VAL = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OFF_W-1:0]    cfg_offset,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                cfg_we,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_valid,
  output logic [NUM_ROWS-1:0] row_cs_n,
  output logic                no_row_hit
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
  localparam int CMP_W  = (UNIT_W > REG_W) ? UNIT_W : REG_W;

  logic [REG_W-1:0]  bnd [NUM_REGS];
  logic [OFF_W-1:0]  delta;
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [CMP_W-1:0]  unit_x;
  logic [NUM_ROWS-1:0] below, sel;
  logic              below_top;

  assign delta    = cfg_offset - OFF_W'(REG_BASE);
  assign idx      = delta[IDX_W-1:0];
  assign in_range = (cfg_offset >= OFF_W'(REG_BASE)) &&
                    ({1'b0, cfg_offset} < ({1'b0, OFF_W'(REG_BASE)} + (OFF_W+1)'(NUM_REGS)));
  assign cfg_rdata = in_range ? bnd[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) bnd[i] <= REG_W'(RESET_VAL);
    end else if (cfg_we && in_range) begin
      bnd[idx] <= cfg_wdata;
    end
  end

  assign unit_x = CMP_W'(host_addr[ADDR_W-1:UNIT_SHIFT]);

  genvar n;
  generate
    for (n = 0; n < NUM_ROWS; n++) begin : g_cmp
      assign below[n] = unit_x < CMP_W'(bnd[n]);
    end
  endgenerate

  assign below_top = below[NUM_ROWS-1];

  always_comb begin
    logic prior;
    prior = 1'b0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      sel[i] = below[i] && !prior && below_top;
      prior  = prior | below[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_cs_n   <= '1;
      no_row_hit <= 1'b0;
    end else if (host_valid) begin
      row_cs_n   <= ~sel;
      no_row_hit <= ~below_top;
    end else begin
      row_cs_n   <= '1;
      no_row_hit <= 1'b0;
    end
  end
endmodule

module dram_row_decoder_chk #(
  parameter int NUM_ROWS = 4,
  parameter int OFF_W    = 8,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 8,
  parameter logic [7:0] REG_BASE = 8'h60
) (
  input logic                clk,
  input logic                rst_n,
  input logic [OFF_W-1:0]    cfg_offset,
  input logic [REG_W-1:0]    cfg_rdata,
  input logic                host_valid,
  input logic [NUM_ROWS-1:0] row_cs_n,
  input logic                no_row_hit
);
  logic stray;
  assign stray = (cfg_offset < OFF_W'(REG_BASE)) ||
                 ({1'b0, cfg_offset} >= ({1'b0, OFF_W'(REG_BASE)} + (OFF_W+1)'(NUM_REGS)));

  a_r7_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_cs_n));
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> ($countones({~row_cs_n, no_row_hit}) == 1));
  a_r6_nohit_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    no_row_hit |-> (&row_cs_n));
  a_r8_idle_after_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> ((&row_cs_n) && !no_row_hit));
  a_r2_stray_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stray |-> (cfg_rdata == '0));
endmodule

bind dram_row_decoder dram_row_decoder_chk #(
  .NUM_ROWS(NUM_ROWS), .OFF_W(OFF_W), .REG_W(REG_W),
  .NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_rdata(cfg_rdata),
  .host_valid(host_valid), .row_cs_n(row_cs_n), .no_row_hit(no_row_hit)
);

// File: tb/test_dram_row_decoder.sv
module test_dram_row_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_offset = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [31:0] host_addr = '0;
  logic        host_valid = 1'b0;
  logic [3:0]  row_cs_n;
  logic        no_row_hit;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [8];

  typedef struct {
    logic [3:0] cs;
    logic       nh;
    string      tag;
    logic [31:0] addr;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  dram_row_decoder i_dram_row_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .host_addr(host_addr),
    .host_valid(host_valid), .row_cs_n(row_cs_n), .no_row_hit(no_row_hit)
  );

  function automatic void model(input logic [31:0] a, output logic [3:0] cs, output logic nh);
    int u;
    u  = int'(a >> 23);
    cs = 4'hF;
    nh = (u >= int'(shadow[3]));
    if (!nh)
      for (int n = 0; n < 4; n++)
        if (u < int'(shadow[n])) begin cs[n] = 1'b0; break; end
  endfunction

  task automatic probe(input logic [31:0] a, input string tag);
    exp_t e;
    model(a, e.cs, e.nh);
    e.tag = tag; e.addr = a;
    @(negedge clk);
    host_addr = a; host_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic edges(input int b, input string tag);
    if (b > 0) probe(32'((b << 23) - 1), tag);
    probe(32'(b << 23), tag);
  endtask

  task automatic wreg(input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    cfg_offset = o; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (o >= 8'h60 && o <= 8'h67) shadow[o - 8'h60] = d;
  endtask

  task automatic rchk(input logic [7:0] o, input string tag);
    logic [7:0] ex;
    ex = (o >= 8'h60 && o <= 8'h67) ? shadow[o - 8'h60] : 8'h00;
    @(negedge clk);
    cfg_offset = o;
    #1;
    checks++;
    if (cfg_rdata !== ex) begin
      fails++;
      $display("FAIL %s read %02h: actual %02h expected %02h", tag, o, cfg_rdata, ex);
    end
  endtask

  task automatic idle_chk(input string tag);
    checks++;
    if (row_cs_n !== 4'hF || no_row_hit !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: actual cs=%b nh=%b expected cs=1111 nh=0", tag, row_cs_n, no_row_hit);
    end
  endtask

  task automatic prog4(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    wreg(8'h60, a); wreg(8'h61, b); wreg(8'h62, c); wreg(8'h63, d);
  endtask

  initial begin : monitor
    forever begin
      logic cap;
      @(posedge clk);
      cap = host_valid;
      #2;
      if (cap && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (row_cs_n !== e.cs || no_row_hit !== e.nh) begin
          fails++;
          $display("FAIL %s addr %08h: actual cs=%b nh=%b expected cs=%b nh=%b",
                   e.tag, e.addr, row_cs_n, no_row_hit, e.cs, e.nh);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 8; i++) shadow[i] = 8'h01;
    repeat (3) @(negedge clk);
    #1 idle_chk("R10");
    rst_n = 1'b1;
    @(negedge clk); #1 idle_chk("R10");

    for (int i = 0; i < 8; i++) rchk(8'(8'h60 + i), "R1");

    probe(32'h0, "R4");
    edges(1, "R6");
    @(negedge clk); #1 idle_chk("R8");

    prog4(8'd2, 8'd4, 8'd4, 8'd7);
    for (int i = 0; i < 4; i++) rchk(8'(8'h60 + i), "R1");
    edges(2, "R3");
    edges(4, "R5");
    edges(7, "R6");
    probe(32'h0180_0000, "R5");
    probe(32'hFFFF_FFFF, "R6");

    wreg(8'h64, 8'hFF); wreg(8'h65, 8'h00); wreg(8'h66, 8'h80); wreg(8'h67, 8'h03);
    for (int i = 4; i < 8; i++) rchk(8'(8'h60 + i), "R1");
    edges(2, "R9"); edges(4, "R9"); edges(7, "R9");

    wreg(8'h5F, 8'hAA); wreg(8'h68, 8'hBB); wreg(8'hFF, 8'hCC); wreg(8'h00, 8'hDD);
    for (int i = 0; i < 8; i++) rchk(8'(8'h60 + i), "R2");
    rchk(8'h5F, "R2"); rchk(8'h68, "R2"); rchk(8'hFF, "R2");
    edges(2, "R2"); edges(7, "R2");

    prog4(8'd3, 8'd1, 8'd5, 8'd9);
    edges(1, "R5"); edges(3, "R5"); edges(5, "R5"); edges(9, "R6");

    prog4(8'd0, 8'd2, 8'd2, 8'd3);
    edges(0, "R4"); edges(2, "R5"); edges(3, "R6");

    prog4(8'd6, 8'd2, 8'd9, 8'd4);
    edges(2, "R5"); edges(4, "R6"); edges(6, "R6");

    prog4(8'd0, 8'd0, 8'd0, 8'd0);
    probe(32'h0, "R6"); probe(32'h0080_0000, "R6");

    prog4(8'd1, 8'd2, 8'd3, 8'hFF);
    edges(255, "R3"); edges(3, "R5");
    @(negedge clk); #1 idle_chk("R8");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending results: actual %0d expected 0", q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule